// File: doc/BRIEF.md
# Page Buffer Write Sequencer

This block models the write engine of a byte-wide nonvolatile memory. Host byte-loads reach it already decoded as one-clock events that carry an address and a data byte. The low seven address bits select a column of a 128-byte page buffer, and the bits above them select a page. While the load cycle is open, each byte goes into the buffer. Every accepted byte restarts a short acceptance window. When a longer idle time passes with no accepted byte, the load cycle closes and a timed internal write commits the whole buffer to the page named by the last accepted byte.

The commit erases and programs the page in one pass, so columns that were never loaded become FFH. While the commit runs, the block is busy and reads return a status byte instead of array data. That status byte carries a polling bit and a toggle bit. When the commit ends, the buffer is back to all FFH and busy drops.

Every time limit is a parameter counted in pulses of a `tick` timebase input, so the microsecond and millisecond limits map onto any clock.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` and `load_open` are 0, `rd_data` is 00H and every array byte reads FFH.
- R2: A byte-load in idle opens the load cycle (`load_open`=1). A byte-load that arrives while the acceptance window is open is accepted and restarts both the window and the idle count. Fewer than WIN_TICKS ticks since the previous accepted byte means the window is open.
- R3: When IDLE_TICKS ticks pass after the last accepted byte, the commit starts: `busy` rises on that tick's clock edge and `load_open` falls. Clocks without `tick` high do not count.
- R4: A byte-load that arrives in the load cycle after the window has lapsed is discarded. It does not restart the idle count, and it is not written.
- R5: A second load to a column before the commit replaces the buffered byte.
- R6: The committed page is given by address bits [ADDR_W-1:7] of the last accepted byte. Other pages are unchanged.
- R7: The commit rewrites all 128 bytes of the target page. Columns not loaded in this cycle become FFH, whatever the page held before.
- R8: `busy` stays high for at least WR_TICKS ticks and at least 128 clocks after the commit starts. Byte-loads during `busy` are ignored.
- R9: A read during `busy` returns a status byte, with bits [5:0] at 0:
  - bit 7 is the complement of bit 7 of the last accepted byte;
  - bit 6 is 1 on the first status read of a commit and alternates on each further status read.
- R10: After a commit the buffer is all FFH. Bytes from an earlier load cycle never reach a later page.
- R11: Outside `busy`, a read returns the array byte one clock after `rd_valid`. During a load cycle this is the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse; all timeouts count these |
| ld_valid | input | 1 | Byte-load event this clock |
| ld_addr | input | ADDR_W | Byte-load address (page and column) |
| ld_data | input | 8 | Byte-load data |
| rd_valid | input | 1 | Read request this clock |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result or status byte, one clock after request |
| busy | output | 1 | Internal write in progress |
| load_open | output | 1 | Page load cycle open |

## Verification
The bench builds the block with a 512-byte array (four pages), a window of 4 ticks, an idle timeout of 8 ticks and a write time of 200 ticks.

With these values, an accepted byte, a late byte and the idle timeout fit inside a dozen clocks, so each can be placed on an exact clock. The write time is longer than the 128-clock buffer drain, so the measured busy length shows the timer rather than the copy.

Four pages are enough to show that a load cycle touching two pages commits only the last one, and that the other pages keep their contents.

// File: rtl/pws_pkg.sv
package pws_pkg;

  localparam int PAGE_BYTES = 128;
  localparam int COL_W      = 7;
  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LOAD   = 2'd1,
    SEQ_COMMIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pws_load_timer.sv
module pws_load_timer #(
  parameter int WIN_TICKS  = 100,
  parameter int IDLE_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic rearm,
  output logic win_open,
  output logic idle_done
);

  localparam int AGE_W = $clog2(IDLE_TICKS + 1);
  localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(IDLE_TICKS);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(IDLE_TICKS - 1);
  localparam logic [AGE_W-1:0] AGE_WIN  = AGE_W'(WIN_TICKS);

  logic [AGE_W-1:0] age;

  // ticks since the last accepted byte-load, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
    end else if (rearm) begin
      age <= '0;
    end else if (run && tick && age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end

  assign win_open  = (age < AGE_WIN);
  assign idle_done = run && tick && !rearm && (age == AGE_LAST);

  // R2: an accepted byte restarts the count
  assert_rearm_clears_age_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (age == '0));

  // R4: no rearm once the window has lapsed
  assert_no_rearm_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_open) |-> !rearm);

endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf
  import pws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [7:0]       wr_data,
  input  logic             clr_en,
  input  logic [COL_W-1:0] clr_col,
  input  logic [COL_W-1:0] rd_col,
  output logic [7:0]       rd_data
);

  logic [7:0] cells [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= ERASED;
    end else begin
      if (wr_en)  cells[wr_col]  <= wr_data;
      if (clr_en) cells[clr_col] <= ERASED;
    end
  end

  assign rd_data = cells[rd_col];

  // R8: host loads never collide with the drain of a commit
  assert_no_load_during_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));

endmodule

// File: rtl/pws_array.sv
module pws_array
  import pws_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pws_status.sv
module pws_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       cap_bit7,
  input  logic       restart,
  input  logic       st_rd,
  output logic [7:0] st_byte
);

  logic poll_q;
  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      tog    <= 1'b0;
    end else begin
      if (capture) poll_q <= cap_bit7;
      if (restart) tog <= 1'b0;
      else if (st_rd) tog <= ~tog;
    end
  end

  assign st_byte = {~poll_q, ~tog, 6'b0};

  // R9: each status read flips the toggle bit
  assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !restart) |=> (tog != $past(tog)));

  // R9: the polling bit is frozen while status reads are served
  assert_poll_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !capture) |=> $stable(poll_q));

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WIN_TICKS  = 100,
  parameter int IDLE_TICKS = 200,
  parameter int WR_TICKS   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              load_open
);

  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int WR_W   = $clog2(WR_TICKS + 1);
  localparam logic [WR_W-1:0]  WR_END   = WR_W'(WR_TICKS);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] p,
                                                  input logic [COL_W-1:0]  c);
    return {p, c};
  endfunction

  seq_state_e state;

  logic              win_open;
  logic              idle_done;
  logic              accept;
  logic              commit_start;
  logic              commit_done;
  logic              copy_step;
  logic              st_rd;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  cidx;
  logic              copy_done;
  logic [WR_W-1:0]   wr_cnt;
  logic [7:0]        buf_byte;
  logic [7:0]        arr_byte;
  logic [7:0]        st_byte;

  // named internal events
  assign accept       = ld_valid && ((state == SEQ_IDLE) ||
                                     (state == SEQ_LOAD && win_open));
  assign commit_start = (state == SEQ_LOAD) && idle_done;
  assign commit_done  = (state == SEQ_COMMIT) && copy_done && (wr_cnt == WR_END);
  assign copy_step    = (state == SEQ_COMMIT) && !copy_done;
  assign st_rd        = rd_valid && busy;

  assign busy      = (state == SEQ_COMMIT);
  assign load_open = (state == SEQ_LOAD);

  pws_load_timer #(
    .WIN_TICKS (WIN_TICKS),
    .IDLE_TICKS(IDLE_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (load_open),
    .rearm    (accept),
    .win_open (win_open),
    .idle_done(idle_done)
  );

  pws_page_buf u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept),
    .wr_col (col_of(ld_addr)),
    .wr_data(ld_data),
    .clr_en (copy_step),
    .clr_col(cidx),
    .rd_col (cidx),
    .rd_data(buf_byte)
  );

  pws_array #(
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (copy_step),
    .wr_addr(join_addr(page_q, cidx)),
    .wr_data(buf_byte),
    .rd_addr(rd_addr),
    .rd_data(arr_byte)
  );

  pws_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .cap_bit7(ld_data[7]),
    .restart (commit_start),
    .st_rd   (st_rd),
    .st_byte (st_byte)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE:   if (accept)       state <= SEQ_LOAD;
        SEQ_LOAD:   if (commit_start) state <= SEQ_COMMIT;
        SEQ_COMMIT: if (commit_done)  state <= SEQ_IDLE;
        default:                      state <= SEQ_IDLE;
      endcase
    end
  end

  // target page follows the last accepted byte
  always_ff @(posedge clk) begin
    if (!rst_n) page_q <= '0;
    else if (accept) page_q <= page_of(ld_addr);
  end

  // drain of the buffer into the page and write timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cidx      <= '0;
      copy_done <= 1'b1;
      wr_cnt    <= '0;
    end else if (commit_start) begin
      cidx      <= '0;
      copy_done <= 1'b0;
      wr_cnt    <= '0;
    end else if (busy) begin
      if (copy_step) begin
        cidx <= cidx + 1'b1;
        if (cidx == COL_LAST) copy_done <= 1'b1;
      end
      if (tick && wr_cnt != WR_END) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // read port: status while busy, array otherwise
  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_valid) rd_data <= busy ? st_byte : arr_byte;
  end

  // R3: a commit only begins from an idle timeout
  assert_commit_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(idle_done));

  // R8: busy holds until both the copy and the timer are finished
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(copy_done && wr_cnt == WR_END)) |=> busy);

  // R6: the target page cannot move during a commit
  assert_page_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));

  // R7: the drain never leaves the page and ends before busy drops
  assert_drain_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> copy_done);

endmodule

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;
  localparam int WIN        = 4;
  localparam int IDLE       = 8;
  localparam int WR         = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic              ld_valid = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [7:0]        ld_data = '0;
  logic              rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              busy;
  logic              load_open;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_seq #(
    .ADDR_W(ADDR_W), .WIN_TICKS(WIN), .IDLE_TICKS(IDLE), .WR_TICKS(WR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .load_open(load_open)
  );

  function automatic logic [ADDR_W-1:0] at(input int page, input int col);
    return ADDR_W'(page * 128 + col);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_free();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", "busy", busy, 0);
    check("R1", "load_open", load_open, 0);
    check("R1", "rd_data", rd_data, 8'h00);
    rd(at(0, 0), d);   check("R1", "array first", d, 8'hFF);
    rd(at(3, 127), d); check("R1", "array last", d, 8'hFF);
  endtask

  task automatic t_page_basic();
    logic [7:0] d;
    load(at(1, 0), 8'h12);
    check("R2", "open after first load", load_open, 1);
    repeat (2) @(negedge clk);
    load(at(1, 5), 8'h3C);              // k=3 from first: inside window
    rd(at(1, 0), d);                    // k=1 from second
    check("R11", "old contents during load", d, 8'hFF);
    repeat (IDLE - 2) @(negedge clk);   // k=IDLE-1
    check("R2", "still loading (rearmed)", busy, 0);
    check("R3", "busy before idle timeout", busy, 0);
    @(negedge clk);                     // k=IDLE
    check("R3", "busy at idle timeout", busy, 1);
    check("R3", "load closed", load_open, 0);
    rd(at(1, 0), d); check("R9", "status 1", d, 8'hC0);
    rd(at(1, 0), d); check("R9", "status 2", d, 8'h80);
    rd(at(2, 4), d); check("R9", "status 3", d, 8'hC0);
    wait_free();
    rd(at(1, 0), d); check("R11", "col0 after commit", d, 8'h12);
    rd(at(1, 5), d); check("R7", "col5 after commit", d, 8'h3C);
    rd(at(1, 9), d); check("R7", "unloaded col", d, 8'hFF);
  endtask

  task automatic t_replace_page();
    logic [7:0] d;
    load(at(2, 3), 8'h11);
    load(at(3, 3), 8'h22);
    load(at(3, 3), 8'h33);
    load(at(3, 4), 8'h9A);
    repeat (IDLE) @(negedge clk);
    check("R3", "commit started", busy, 1);
    rd(at(0, 0), d); check("R9", "poll bit of last byte", d, 8'h40);
    wait_free();
    rd(at(3, 3), d); check("R5", "replaced byte", d, 8'h33);
    rd(at(3, 4), d); check("R6", "last page written", d, 8'h9A);
    rd(at(2, 3), d); check("R6", "earlier page untouched", d, 8'hFF);
    rd(at(1, 5), d); check("R6", "other page kept", d, 8'h3C);
  endtask

  task automatic t_late();
    logic [7:0] d;
    load(at(0, 1), 8'hA1);
    repeat (5) @(negedge clk);
    load(at(0, 2), 8'hB2);              // k=6: window lapsed
    @(negedge clk);                     // k=7
    check("R4", "late byte no rearm (not yet)", busy, 0);
    @(negedge clk);                     // k=8
    check("R4", "late byte no rearm", busy, 1);
    wait_free();
    rd(at(0, 1), d); check("R4", "accepted byte", d, 8'hA1);
    rd(at(0, 2), d); check("R4", "late byte discarded", d, 8'hFF);
  endtask

  task automatic t_overwrite();
    logic [7:0] d;
    load(at(1, 7), 8'h07);
    repeat (IDLE) @(negedge clk);
    wait_free();
    rd(at(1, 7), d); check("R7", "new byte", d, 8'h07);
    rd(at(1, 0), d); check("R7", "old byte erased", d, 8'hFF);
    rd(at(1, 5), d); check("R7", "old byte erased 2", d, 8'hFF);
    rd(at(1, 3), d); check("R10", "no stale buffer byte", d, 8'hFF);
    rd(at(1, 4), d); check("R10", "no stale buffer byte 2", d, 8'hFF);
  endtask

  task automatic t_commit_len();
    logic [7:0] d;
    load(at(2, 0), 8'h5A);
    repeat (IDLE) @(negedge clk);       // entry edge just passed
    check("R8", "busy at entry", busy, 1);
    repeat (10) @(negedge clk);
    load(at(0, 9), 8'h77);              // ignored
    check("R8", "no load cycle during busy", load_open, 0);
    repeat (WR - 16) @(negedge clk);
    check("R8", "busy near write time", busy, 1);
    repeat (10) @(negedge clk);
    check("R8", "busy dropped after write time", busy, 0);
    check("R8", "still no load cycle", load_open, 0);
    rd(at(0, 9), d); check("R8", "load during busy ignored", d, 8'hFF);
    rd(at(2, 0), d); check("R8", "committed byte", d, 8'h5A);
  endtask

  task automatic t_tick_gate();
    load(at(3, 0), 8'h01);
    tick = 1'b0;
    repeat (20) @(negedge clk);
    check("R3", "no timeout without ticks", busy, 0);
    check("R3", "cycle open without ticks", load_open, 1);
    tick = 1'b1;
    repeat (IDLE - 1) @(negedge clk);
    check("R3", "gated: before timeout", busy, 0);
    @(negedge clk);
    check("R3", "gated: at timeout", busy, 1);
    wait_free();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_basic();
    t_replace_page();
    t_late();
    t_overwrite();
    t_commit_len();
    t_tick_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule